// File: doc/BRIEF.md
# Scanline Interrupt Counter with A12 Low-Time Filter

This block counts rising edges of graphics address bit 12 and uses them as a scanline clock. Each rise of that line marks one scanline. When a programmed number of scanlines has gone by, the block raises a level interrupt request. Software reaches the block through four decoded write registers. One sets the reload value, one forces a reload, one enables the request, and one disables it and acknowledges a pending request.

The reload value is kept in complemented form, so a written byte `w` gives a period of `(~w)+1` scanlines. A rise of bit 12 counts only if the line has first been low for a minimum number of CPU clock-enable cycles. Short glitches on the line during a scanline therefore do not clock the counter. Everything runs on one clock. The CPU rate is given as a clock enable.

Top module: `line_irq_counter`

## Requirements
- R1: A write to the latch register (select 0) stores the bitwise complement of `wr_data` as the reload value. For example, writing 5 gives a reload value of 0xFA.
- R2: A write to the reload register (select 1) sets the counter to 0 and sets a reload flag. The next counter step then loads the reload value, even in the middle of a count.
- R3: On each counter step, if the counter is 0 or the reload flag is set, the counter takes the reload value and the flag clears. Otherwise the counter decrements by 1.
- R4: If the counter is 0 after a step and the request is enabled, `irq_pending` goes high at that step. It stays high until a disable write, however many more steps follow.
- R5: A write to the enable register (select 2) enables the request. A write to the disable register (select 3) clears the enable and clears `irq_pending` on the next clock. While the request is disabled, steps never set `irq_pending`.
- R6: A rise of `gfx_a12` (low at the previous clock, high now) is a counter step only if the line was low during at least `LOW_MIN` (default 3) clocks with `cpu_ce` high. Low clocks with `cpu_ce` low do not count.
- R7: Whenever `gfx_a12` is high, the low-time count returns to zero. A low pulse shorter than `LOW_MIN` enabled cycles between two high periods produces no step.
- R8: Reset clears the reload value, the counter, the reload flag, the enable and `irq_pending`. It arms the filter as if `gfx_a12` had been high.
- R9: After a reload write and an enable, with latch data `w`, `irq_pending` first rises on qualified rise number `(~w & 0xFF)+1`. So latch 0xFF fires on the first rise, and latch 5 fires on rise 0xFB and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | CPU cycle enable, advances the low-time filter |
| gfx_a12 | input | 1 | Graphics address bit 12 |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_sel | input | 2 | Register select: 0 latch, 1 reload, 2 enable, 3 disable |
| wr_data | input | CNT_W | Write data (used by the latch register) |
| irq_pending | output | 1 | Level interrupt request, active high |

## Verification
The counter, the reload flag and the filter are not visible at the ports. A wrong value in any of them shows only as `irq_pending` rising on the wrong qualified rise. A counter that is off by one, for example, moves the firing by exactly one scanline, on the rise where firing was expected. A filter threshold that is off by one makes a rise after a low time of exactly `LOW_MIN` cycles, or one cycle short of it, behave the wrong way. This appears on the clock right after that rise. For these reasons the bench sweeps the period over many latch values and the low time over each length around the threshold.

// File: rtl/line_irq_counter.sv
module line_irq_counter #(
  parameter int CNT_W   = 8,
  parameter int LOW_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_ce,
  input  logic             gfx_a12,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             irq_pending
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam logic [1:0] SEL_LATCH = 2'd0, SEL_RELOAD = 2'd1, SEL_ON = 2'd2, SEL_OFF = 2'd3;

  logic             a12_q;
  logic [LW-1:0]    low_cnt;
  logic [CNT_W-1:0] reload_val, cnt, cnt_next;
  logic             reload_flag, irq_en;

  wire armed     = (low_cnt == LW'(LOW_MIN));
  wire step      = gfx_a12 & ~a12_q & armed;
  wire wr_latch  = wr_en && (wr_sel == SEL_LATCH);
  wire wr_reload = wr_en && (wr_sel == SEL_RELOAD);
  wire wr_on     = wr_en && (wr_sel == SEL_ON);
  wire wr_off    = wr_en && (wr_sel == SEL_OFF);

  assign cnt_next = (cnt == '0 || reload_flag) ? reload_val : cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a12_q   <= 1'b1;
      low_cnt <= '0;
    end else begin
      a12_q <= gfx_a12;
      if (gfx_a12)
        low_cnt <= '0;
      else if (cpu_ce && !armed)
        low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_val  <= '0;
      cnt         <= '0;
      reload_flag <= 1'b0;
      irq_en      <= 1'b0;
      irq_pending <= 1'b0;
    end else begin
      if (wr_latch) reload_val <= ~wr_data;
      if (wr_reload) begin
        cnt         <= '0;
        reload_flag <= 1'b1;
      end else if (step) begin
        cnt         <= cnt_next;
        reload_flag <= 1'b0;
      end
      if (wr_on)       irq_en <= 1'b1;
      else if (wr_off) irq_en <= 1'b0;
      if (wr_off)
        irq_pending <= 1'b0;
      else if (step && !wr_reload && cnt_next == '0 && irq_en)
        irq_pending <= 1'b1;
    end
  end
endmodule

// File: rtl/line_irq_checker.sv
module line_irq_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gfx_a12,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             step,
  input logic [CNT_W-1:0] cnt,
  input logic             reload_flag,
  input logic             irq_pending
);
  a_r2_reload_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> (cnt == '0 && reload_flag));

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload_flag && cnt != '0 && !(wr_en && wr_sel == 2'd1)) |=> (cnt == $past(cnt) - 1'b1));

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !(wr_en && wr_sel == 2'd3)) |=> irq_pending);

  a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> !irq_pending);

  a_r4_rise_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> $past(step));

  a_r6_step_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (gfx_a12 && !$past(gfx_a12)));
endmodule

bind line_irq_counter line_irq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gfx_a12(gfx_a12), .wr_en(wr_en), .wr_sel(wr_sel),
  .step(step), .cnt(cnt), .reload_flag(reload_flag), .irq_pending(irq_pending)
);

// File: tb/tb_line_irq_counter.sv
module tb_line_irq_counter;
  logic clk = 1'b0, rst_n = 1'b0, cpu_ce = 1'b1, gfx_a12 = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic irq_pending;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  line_irq_counter dut (.clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .gfx_a12(gfx_a12),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_pending(irq_pending));

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq_pending=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rise(input int low);
    gfx_a12 = 1'b0;
    repeat (low) @(negedge clk);
    gfx_a12 = 1'b1;
    @(negedge clk);
  endtask

  task automatic arm(input logic [7:0] w);
    wr(2'd3, 8'h00); wr(2'd0, w); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_pending, 1'b0, "R8 reset pending");
    rise(4);
    chk(irq_pending, 1'b0, "R8 enable cleared by reset");

    arm(8'hFF);
    rise(3);
    chk(irq_pending, 1'b1, "R9 latch FF fires on first rise");
    rise(3);
    chk(irq_pending, 1'b1, "R4 pending sticky");
    wr(2'd3, 8'h00);
    chk(irq_pending, 1'b0, "R5 disable clears pending");
    rise(3);
    chk(irq_pending, 1'b0, "R5 no pending while disabled");

    // R1 R9: period sweep, fires on rise (~w)+1
    for (int w = 255; w >= 192; w--) begin
      int n;
      n = ((~w) & 8'hFF) + 1;
      arm(8'(w));
      repeat (n - 1) rise(3);
      chk(irq_pending, 1'b0, "R9 no early fire");
      rise(3);
      chk(irq_pending, 1'b1, "R1 fire on rise (~w)+1");
    end
    arm(8'd5);
    repeat (250) rise(3);
    chk(irq_pending, 1'b0, "R9 latch 5 silent through 0xFA rises");
    rise(3);
    chk(irq_pending, 1'b1, "R9 latch 5 fires on rise 0xFB");

    // R3: counter restarts from the reload value after reaching 0
    arm(8'hFD);
    repeat (3) rise(3);
    chk(irq_pending, 1'b1, "R3 first period");
    wr(2'd3, 8'h00); wr(2'd2, 8'h00);
    repeat (2) rise(3);
    chk(irq_pending, 1'b0, "R3 reload from zero, no early fire");
    rise(3);
    chk(irq_pending, 1'b1, "R3 second period length");

    // R2: reload mid count restarts the full period
    arm(8'hF5);
    repeat (5) rise(3);
    wr(2'd1, 8'h00);
    repeat (10) rise(3);
    chk(irq_pending, 1'b0, "R2 mid-count reload restarts");
    rise(3);
    chk(irq_pending, 1'b1, "R2 fire after full period");

    // R6: low-time sweep around the threshold
    for (int low = 0; low <= 5; low++) begin
      arm(8'hFF);
      rise(low);
      chk(irq_pending, low >= 3, "R6 low-time threshold");
    end
    arm(8'hFF);
    cpu_ce = 1'b0;
    rise(6);
    chk(irq_pending, 1'b0, "R6 low cycles without cpu_ce ignored");
    cpu_ce = 1'b1;
    rise(3);
    chk(irq_pending, 1'b1, "R6 enabled low cycles count");

    // R7: short pulses between high periods never accumulate
    arm(8'hFF);
    rise(2); rise(2); rise(1); rise(2);
    chk(irq_pending, 1'b0, "R7 rapid toggles give no step");
    rise(3);
    chk(irq_pending, 1'b1, "R7 full low time steps");

    // R8: reset mid-operation clears pending and re-arms filter
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_pending, 1'b0, "R8 reset clears pending");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule